// File: doc/BRIEF.md
# Layer-Selectable Bias and Activation Unit

This block is the last arithmetic step of a convolution engine. For every output pixel it takes the finished convolution sum and adds a bias held in one of a small bank of per-output-channel registers. It then applies the activation that belongs to the layer being computed. Batch normalization has already been folded into the weights and into that bias, so a single saturating add replaces it, and the block has no divider.

The layer number travels with each pixel, and the activation is chosen from it. One code passes the biased value through unchanged. A range of codes applies ReLU, built as a multiplexer driven by the sign bit. One code applies tanh: the biased value is rounded and saturated to an 8-bit signed index, and that index reads a 256-entry table. The table contents are computed from the tanh function when the design is elaborated. The unit has a two-stage pipeline and accepts a new pixel on every cycle. The layer can change from one pixel to the next without an idle cycle.

Top module: `bias_act_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_data` is 0, and every bias register holds 0, so a pixel in layer 1 comes out equal to its input sum.
- R2: The biased value is the signed sum of `in_sum` and the bias register selected by `in_chan`, saturated to the signed range of `SUM_W` bits (-524288 to 524287 at the default width).
- R3: For layer code 1, and for any layer code outside 2 to 6, `out_data` equals the biased value.
- R4: For layer codes 2, 3, 4 and 5, `out_data` is 0 when the biased value has its sign bit set, and equals the biased value otherwise.
- R5: For layer code 6, the index is the biased value divided by 2^(IN_FRAC-IDX_FRAC) (8 at the defaults), rounded with halves toward plus infinity, then clamped to [-128, 127]. `out_data` is round-to-nearest(tanh(index / 2^IDX_FRAC) * 127), sign-extended, so it always lies in [-127, 127].
- R6: Every accepted input (`in_valid` = 1) produces exactly one output with `out_valid` = 1 two clock edges later. Inputs on consecutive cycles give outputs on consecutive cycles, each one using its own layer code and channel.
- R7: When `bias_we` = 1 at a clock edge, `bias_data` is written into register `bias_addr`. A pixel presented in that same cycle still uses the old value, and later pixels use the new one. The other registers are unchanged.
- R8: While `out_valid` is 0, `out_data` keeps the value of the last output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel is present |
| in_sum | input | SUM_W | Signed convolution sum |
| in_chan | input | CH_W | Output channel, selects the bias register |
| in_layer | input | LAYER_W | Layer code of this pixel |
| bias_we | input | 1 | Bias register write enable |
| bias_addr | input | CH_W | Bias register to write |
| bias_data | input | SUM_W | Signed bias value to write |
| out_valid | output | 1 | Output pixel is present |
| out_data | output | SUM_W | Signed activated result |

## Verification
Two situations are hardest to reach from the ports. The first is a bias write in the same cycle as a pixel that reads the same channel. The second is a stream in which each pixel carries a different layer code, so the activation selection must follow its own pixel through both pipeline stages. The directed stream task places a write and a matching pixel on the same negative edge, and then sends the same pixel again on the next cycle. It also sends runs of back-to-back pixels that step through layers 1, 3, 6, 0 and 5. Sums at and past the saturation limits, and sums that fall exactly on a rounding half, exercise the clamp and rounding of the tanh index.

// File: rtl/bias_act_pkg.sv
// Package: shared types and layer-code constants for the bias/activation unit.
// Assumes layer codes are small unsigned integers.
package bias_act_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_RELU = 2'd1,
        ACT_TANH = 2'd2
    } act_sel_e;

    localparam int unsigned LAYER_PLAIN = 1;
    localparam int unsigned RELU_FIRST  = 2;
    localparam int unsigned RELU_LAST   = 5;
    localparam int unsigned LAYER_TANH  = 6;

    // Map a layer code onto the activation it uses.
    function automatic act_sel_e layer_to_act(input int unsigned code);
        if (code >= RELU_FIRST && code <= RELU_LAST) return ACT_RELU;
        if (code == LAYER_TANH)                      return ACT_TANH;
        return ACT_NONE;
    endfunction

endpackage

// File: rtl/bias_bank.sv
// Module: bias_bank
// Per-output-channel register file that holds the folded biases.
// Has one write port and one combinational read port. A read in the same
// cycle as a write to the same entry returns the old value.
module bias_bank #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 20,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_addr,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic [CH_W-1:0]          rd_addr,
    output logic signed [DATA_W-1:0] rd_data
);

    logic signed [DATA_W-1:0] regs [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        // Clear on reset; load when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_addr == CH_W'(g)))
                regs[g] <= wr_data;
        end
    end

    // Read mux; addresses past NUM_CH return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_addr == CH_W'(i)) rd_data = regs[i];
    end

endmodule

// File: rtl/bias_add_stage.sv
// Module: bias_add_stage
// Pipeline stage 1. Adds the bias to the sum with saturation and registers
// the result together with the activation decoded from the pixel's layer.
// Assumes the bias and the sum have the same width.
module bias_add_stage
    import bias_act_pkg::*;
#(
    parameter int SUM_W   = 20,
    parameter int LAYER_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [SUM_W-1:0] in_sum,
    input  logic signed [SUM_W-1:0] in_bias,
    input  logic [LAYER_W-1:0]      in_layer,
    output logic                    s1_valid,
    output logic signed [SUM_W-1:0] s1_value,
    output act_sel_e                s1_sel
);

    localparam int WIDE_W = SUM_W + 1;
    localparam logic signed [WIDE_W-1:0] HI = WIDE_W'((2 ** (SUM_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] LO = -HI - WIDE_W'(1);

    logic signed [WIDE_W-1:0] wide_sum;
    logic signed [SUM_W-1:0]  sat_sum;

    // One extra bit of headroom for the add, then clamp back to SUM_W.
    always_comb begin
        wide_sum = WIDE_W'(in_sum) + WIDE_W'(in_bias);
        if (wide_sum > HI)
            sat_sum = HI[SUM_W-1:0];
        else if (wide_sum < LO)
            sat_sum = LO[SUM_W-1:0];
        else
            sat_sum = wide_sum[SUM_W-1:0];
    end

    // Register the valid flag every cycle; register the payload only on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_value <= '0;
            s1_sel   <= ACT_NONE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_value <= sat_sum;
                s1_sel   <= layer_to_act(int'(in_layer));
            end
        end
    end

endmodule

// File: rtl/tanh_lut.sv
// Module: tanh_lut
// Combinational tanh. Rounds the input down to a CODE_W-bit signed index
// (halves go toward plus infinity) and saturates it, then reads a table
// with 2^CODE_W entries. The table is computed at elaboration: entry k holds
// round(tanh(k / 2^IDX_FRAC) * (2^(CODE_W-1) - 1)).
module tanh_lut #(
    parameter int IN_W     = 20,
    parameter int IN_FRAC  = 8,
    parameter int IDX_FRAC = 5,
    parameter int CODE_W   = 8
) (
    input  logic signed [IN_W-1:0]   value,
    output logic signed [CODE_W-1:0] code
);

    localparam int SHIFT   = IN_FRAC - IDX_FRAC;
    localparam int WW      = IN_W + 1;
    localparam int ENTRIES = 2 ** CODE_W;
    localparam int MAXC    = (2 ** (CODE_W - 1)) - 1;
    localparam logic signed [WW-1:0] IDX_HI = WW'(MAXC);
    localparam logic signed [WW-1:0] IDX_LO = -IDX_HI - WW'(1);

    // Elaboration-time table entry for signed index k.
    function automatic int tanh_code(input int k);
        real x;
        real y;
        int  r;
        x = real'(k) / (2.0 ** IDX_FRAC);
        y = $tanh(x) * real'(MAXC);
        if (y >= 0.0) r = $rtoi(y + 0.5);
        else          r = -$rtoi(0.5 - y);
        if (r > MAXC)  r = MAXC;
        if (r < -MAXC) r = -MAXC;
        return r;
    endfunction

    logic signed [CODE_W-1:0] table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam logic signed [CODE_W-1:0] ENT = CODE_W'(tanh_code(g - ENTRIES / 2));
        assign table_q[g] = ENT;
    end

    logic signed [WW-1:0]     ext;
    logic signed [WW-1:0]     scaled;
    logic signed [CODE_W-1:0] idx;

    assign ext = WW'(value);

    if (SHIFT > 0) begin : g_round
        // Add half an index step, then shift arithmetically.
        assign scaled = (ext + WW'(1 << (SHIFT - 1))) >>> SHIFT;
    end else begin : g_noround
        assign scaled = ext;
    end

    // Saturate the scaled value into the index range.
    always_comb begin
        if (scaled > IDX_HI)
            idx = IDX_HI[CODE_W-1:0];
        else if (scaled < IDX_LO)
            idx = IDX_LO[CODE_W-1:0];
        else
            idx = scaled[CODE_W-1:0];
    end

    // Offset-binary address: inverting the sign bit maps -2^(CODE_W-1) to entry 0.
    assign code = table_q[{~idx[CODE_W-1], idx[CODE_W-2:0]}];

endmodule

// File: rtl/act_stage.sv
// Module: act_stage
// Pipeline stage 2. Picks the activation for the pixel (passthrough,
// sign-bit ReLU or the tanh code) and registers the result. The output
// holds its value while no pixel is present.
module act_stage
    import bias_act_pkg::*;
#(
    parameter int SUM_W  = 20,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s1_valid,
    input  logic signed [SUM_W-1:0]  s1_value,
    input  act_sel_e                 s1_sel,
    input  logic signed [CODE_W-1:0] tanh_code,
    output logic                     out_valid,
    output logic signed [SUM_W-1:0]  out_data
);

    logic signed [SUM_W-1:0] act_val;

    // Activation mux; the ReLU branch looks only at the sign bit.
    always_comb begin
        unique case (s1_sel)
            ACT_RELU: act_val = s1_value[SUM_W-1] ? '0 : s1_value;
            ACT_TANH: act_val = SUM_W'(tanh_code);
            default:  act_val = s1_value;
        endcase
    end

    // Output register; updates only when a pixel is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_data <= act_val;
        end
    end

endmodule

// File: rtl/bias_act_unit.sv
// Module: bias_act_unit (top)
// Per-pixel bias add and layer-selected activation, two-cycle latency,
// one pixel per cycle. Assumes batch normalization is already folded into
// the bias, and that the sum carries IN_FRAC fractional bits.
module bias_act_unit #(
    parameter int NUM_CH   = 8,
    parameter int SUM_W    = 20,
    parameter int LAYER_W  = 3,
    parameter int IN_FRAC  = 8,
    parameter int IDX_FRAC = 5,
    parameter int CODE_W   = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SUM_W-1:0]   in_sum,
    input  logic [CH_W-1:0]    in_chan,
    input  logic [LAYER_W-1:0] in_layer,
    input  logic               bias_we,
    input  logic [CH_W-1:0]    bias_addr,
    input  logic [SUM_W-1:0]   bias_data,
    output logic               out_valid,
    output logic [SUM_W-1:0]   out_data
);

    import bias_act_pkg::*;

    logic signed [SUM_W-1:0]  bias_rd;
    logic                     s1_valid;
    logic signed [SUM_W-1:0]  s1_value;
    act_sel_e                 s1_sel;
    logic signed [CODE_W-1:0] tcode;
    logic signed [SUM_W-1:0]  res;

    bias_bank #(.NUM_CH(NUM_CH), .DATA_W(SUM_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bias_we),
        .wr_addr (bias_addr),
        .wr_data (bias_data),
        .rd_addr (in_chan),
        .rd_data (bias_rd)
    );

    bias_add_stage #(.SUM_W(SUM_W), .LAYER_W(LAYER_W)) u_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sum   (in_sum),
        .in_bias  (bias_rd),
        .in_layer (in_layer),
        .s1_valid (s1_valid),
        .s1_value (s1_value),
        .s1_sel   (s1_sel)
    );

    tanh_lut #(.IN_W(SUM_W), .IN_FRAC(IN_FRAC), .IDX_FRAC(IDX_FRAC),
               .CODE_W(CODE_W)) u_tanh (
        .value (s1_value),
        .code  (tcode)
    );

    act_stage #(.SUM_W(SUM_W), .CODE_W(CODE_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_value  (s1_value),
        .s1_sel    (s1_sel),
        .tanh_code (tcode),
        .out_valid (out_valid),
        .out_data  (res)
    );

    assign out_data = res;

endmodule

// File: rtl/bias_act_unit_chk.sv
// Module: bias_act_unit_chk
// Assertion checker bound to bias_act_unit. It sees only the top-level ports.
// It keeps its own two-deep pipeline of layer codes so that it can tell which
// activation each output must have come from.
module bias_act_unit_chk
    import bias_act_pkg::*;
#(
    parameter int SUM_W   = 20,
    parameter int LAYER_W = 3,
    parameter int CODE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [LAYER_W-1:0] in_layer,
    input logic               out_valid,
    input logic [SUM_W-1:0]   out_data
);

    localparam int MAXC = (2 ** (CODE_W - 1)) - 1;

    act_sel_e sel_d1;
    act_sel_e sel_d2;

    // Layer-to-activation pipeline, aligned with the design's output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_d1 <= ACT_NONE;
            sel_d2 <= ACT_NONE;
        end else begin
            if (in_valid) sel_d1 <= layer_to_act(int'(in_layer));
            sel_d2 <= sel_d1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));                          // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);                                         // R6

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);                                       // R6

    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sel_d2 == ACT_RELU) |-> !out_data[SUM_W-1]);           // R4

    AST_TANH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sel_d2 == ACT_TANH) |->
        ($signed(out_data) <= MAXC && $signed(out_data) >= -MAXC));          // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));                                   // R8

endmodule

bind bias_act_unit bias_act_unit_chk #(
    .SUM_W   (SUM_W),
    .LAYER_W (LAYER_W),
    .CODE_W  (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_layer  (in_layer),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/bias_act_unit_test.sv
// Directed bench for bias_act_unit. Each scenario task loads a short
// stimulus stream, runs it and checks each output at the negative edge
// two cycles after its input.
`timescale 1ns/1ps
module bias_act_unit_test;

    localparam int NUM_CH = 8;
    localparam int SUM_W  = 20;
    localparam int CH_W   = 3;
    localparam int LAY_W  = 3;
    localparam int SMAX   = (2 ** (SUM_W - 1)) - 1;
    localparam int SMIN   = -(2 ** (SUM_W - 1));
    localparam int MAXS   = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [SUM_W-1:0] in_sum;
    logic [CH_W-1:0]  in_chan;
    logic [LAY_W-1:0] in_layer;
    logic             bias_we;
    logic [CH_W-1:0]  bias_addr;
    logic [SUM_W-1:0] bias_data;
    logic             out_valid;
    logic [SUM_W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    // Stimulus program for one stream
    int st_n;
    bit st_vld [MAXS];
    int st_sum [MAXS];
    int st_ch  [MAXS];
    int st_lay [MAXS];
    bit st_we  [MAXS];
    int st_wa  [MAXS];
    int st_wd  [MAXS];
    string st_req [MAXS];

    int shadow [NUM_CH];
    int last_out;

    always #2.5 clk = ~clk;

    bias_act_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sum    (in_sum),
        .in_chan   (in_chan),
        .in_layer  (in_layer),
        .bias_we   (bias_we),
        .bias_addr (bias_addr),
        .bias_data (bias_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int sat(input int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic int tanh_ref(input int v);
        int  q;
        real y;
        q = (v + 4) >>> 3;
        if (q > 127)  q = 127;
        if (q < -128) q = -128;
        y = $tanh(real'(q) / 32.0) * 127.0;
        if (y >= 0.0) return $rtoi(y + 0.5);
        return -$rtoi(0.5 - y);
    endfunction

    function automatic int model(input int s, input int b, input int lay);
        int v;
        v = sat(s + b);
        if (lay >= 2 && lay <= 5) return (v < 0) ? 0 : v;
        if (lay == 6) return tanh_ref(v);
        return v;
    endfunction

    function automatic int outs();
        return int'($signed(out_data));
    endfunction

    task automatic check(input string req, input bit cond, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        st_n = 0;
    endtask

    task automatic add_step(input bit v, input int s, input int ch, input int lay,
                            input bit we, input int wa, input int wd, input string req);
        st_vld[st_n] = v;  st_sum[st_n] = s;  st_ch[st_n] = ch; st_lay[st_n] = lay;
        st_we[st_n]  = we; st_wa[st_n]  = wa; st_wd[st_n] = wd; st_req[st_n] = req;
        st_n++;
    endtask

    // Drive the program one step per cycle; check output k at step k+2.
    task automatic run_stream();
        int exp_q [MAXS];
        for (int i = 0; i < st_n; i++) begin
            exp_q[i] = model(st_sum[i], shadow[st_ch[i]], st_lay[i]);
            if (st_we[i]) shadow[st_wa[i]] = st_wd[i];
        end
        for (int i = 0; i < st_n + 3; i++) begin
            @(negedge clk);
            if (i >= 2 && i - 2 < st_n) begin
                if (st_vld[i-2]) begin
                    check(st_req[i-2], out_valid == 1'b1, int'(out_valid), 1);
                    check(st_req[i-2], outs() == exp_q[i-2], outs(), exp_q[i-2]);
                    last_out = exp_q[i-2];
                end else begin
                    check("R8", out_valid == 1'b0, int'(out_valid), 0);
                    check("R8", outs() == last_out, outs(), last_out);
                end
            end
            if (i == st_n + 2) begin
                check("R8", out_valid == 1'b0, int'(out_valid), 0);
                check("R8", outs() == last_out, outs(), last_out);
            end
            if (i < st_n) begin
                in_valid  = st_vld[i];
                in_sum    = SUM_W'(st_sum[i]);
                in_chan   = CH_W'(st_ch[i]);
                in_layer  = LAY_W'(st_lay[i]);
                bias_we   = st_we[i];
                bias_addr = CH_W'(st_wa[i]);
                bias_data = SUM_W'(st_wd[i]);
            end else begin
                in_valid = 1'b0;
                bias_we  = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        in_valid = 0; in_sum = '0; in_chan = '0; in_layer = '0;
        bias_we = 0; bias_addr = '0; bias_data = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        check("R1", outs() == 0, outs(), 0);
        rst_n = 1;
        foreach (shadow[i]) shadow[i] = 0;
        last_out = 0;
        // Zero biases after reset: layer-1 pixels on every channel pass unchanged
        clear_prog();
        for (int c = 0; c < NUM_CH; c++) add_step(1, 1000 * c - 3000, c, 1, 0, 0, 0, "R1");
        run_stream();
    endtask

    task automatic t_bias_and_plain();
        clear_prog();
        add_step(0, 0, 0, 1, 1, 1, 500, "R7");
        add_step(0, 0, 0, 1, 1, 2, -700, "R7");
        add_step(1, 123, 1, 1, 0, 0, 0, "R2");
        add_step(1, 123, 2, 1, 0, 0, 0, "R2");
        add_step(1, -50, 1, 0, 0, 0, 0, "R3");
        add_step(1, -50, 2, 7, 0, 0, 0, "R3");
        add_step(1, 9, 3, 1, 0, 0, 0, "R7");
        run_stream();
    endtask

    task automatic t_saturate();
        clear_prog();
        add_step(0, 0, 0, 1, 1, 4, 100, "R2");
        add_step(0, 0, 0, 1, 1, 5, -1, "R2");
        add_step(1, SMAX, 4, 1, 0, 0, 0, "R2");
        add_step(1, SMIN, 5, 1, 0, 0, 0, "R2");
        add_step(1, SMAX - 100, 4, 1, 0, 0, 0, "R2");
        run_stream();
    endtask

    task automatic t_relu();
        clear_prog();
        add_step(1, -1, 0, 2, 0, 0, 0, "R4");
        add_step(1, 0, 0, 3, 0, 0, 0, "R4");
        add_step(1, 77, 0, 4, 0, 0, 0, "R4");
        add_step(1, 400, 2, 5, 0, 0, 0, "R4");
        add_step(1, 800, 2, 5, 0, 0, 0, "R4");
        add_step(1, SMIN, 0, 3, 0, 0, 0, "R4");
        run_stream();
    endtask

    task automatic t_tanh();
        clear_prog();
        add_step(1, 0, 0, 6, 0, 0, 0, "R5");
        add_step(1, 256, 0, 6, 0, 0, 0, "R5");
        add_step(1, -256, 0, 6, 0, 0, 0, "R5");
        add_step(1, 4, 0, 6, 0, 0, 0, "R5");
        add_step(1, -4, 0, 6, 0, 0, 0, "R5");
        add_step(1, -12, 0, 6, 0, 0, 0, "R5");
        add_step(1, 100000, 0, 6, 0, 0, 0, "R5");
        add_step(1, -100000, 0, 6, 0, 0, 0, "R5");
        add_step(1, 1020, 0, 6, 0, 0, 0, "R5");
        add_step(1, 1100, 1, 6, 0, 0, 0, "R5");
        run_stream();
    endtask

    task automatic t_mixed_stream();
        clear_prog();
        add_step(1, -300, 1, 1, 0, 0, 0, "R6");
        add_step(1, -300, 1, 3, 0, 0, 0, "R6");
        add_step(1, -300, 1, 6, 0, 0, 0, "R6");
        add_step(1, -300, 1, 0, 0, 0, 0, "R6");
        add_step(1, 300, 2, 5, 0, 0, 0, "R6");
        add_step(0, 0, 0, 1, 0, 0, 0, "R8");
        add_step(1, 5, 0, 6, 0, 0, 0, "R6");
        run_stream();
    endtask

    task automatic t_write_same_cycle();
        clear_prog();
        add_step(1, 1000, 6, 1, 1, 6, 250, "R7");
        add_step(1, 1000, 6, 1, 0, 0, 0, "R7");
        add_step(1, 1000, 7, 1, 1, 6, -2000, "R7");
        add_step(1, 1000, 6, 2, 0, 0, 0, "R7");
        run_stream();
    endtask

    initial begin
        t_reset();
        t_bias_and_plain();
        t_saturate();
        t_relu();
        t_tanh();
        t_mixed_stream();
        t_write_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5.0);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule